// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank

This block holds the configuration of one video processing path as pairs of registers. Software writes a working copy of each field through a simple write port. The datapath sees only the matching shadow copy, so a half-written set of values never reaches it. The shadow copies are refreshed from the working copies in two ways. An immediate commit is requested by writing the control word with its one-shot bit set. A deferred commit happens on a frame-end pulse while the sticky auto-commit bit is set, which lets one path be reprogrammed while a neighbouring path keeps streaming.

Each read returns the pending value and the active value of one register side by side, so software can see what has been staged and what the datapath is using. The path is switched off by writing zero to the control field and committing it. Reset clears every working and shadow register, which leaves the path disabled.

Top module: `cfg_shadow_bank`

## Requirements
- R1: After reset every working register, every shadow register and the auto-commit bit are zero, so every read returns zero and `active_ctrl_o` and `active_field_o` are zero.
- R2: A write changes only the addressed working register. The shadow registers and the active outputs keep their values until a commit happens.
- R3: A write to address 0 with bit 8 (the one-shot commit bit, bit CTRL_W) set copies every working register into its shadow one clock edge after the write's edge. The newly written control value is part of that copy.
- R4: The one-shot commit bit is not stored. Reading address 0 always returns bit 8 as zero.
- R5: While the auto-commit bit (bit 9 of address 0, bit CTRL_W+1) is set, the clock edge that samples `frame_end_i` high copies every working register into its shadow. Before that edge the active outputs do not change.
- R6: A frame-end pulse has no effect while the auto-commit bit is clear.
- R7: The auto-commit bit stays set until software clears it, so every later frame-end pulse commits again. It reads back at bit 9 of address 0.
- R8: If a one-shot commit and a frame-end commit fall on the same edge, exactly one copy of the working values from before that edge is made. A field write on that same edge stays pending.
- R9: Reading an address returns the working value in bits [15:0] and the shadow value in bits [31:16]. Address 0 is the control word: control field in bits [7:0], auto-commit bit at 9, shadow control field in bits [23:16]. Addresses 1 to NUM_FIELDS are fields 0 to NUM_FIELDS-1.
- R10: Writes to addresses above NUM_FIELDS change no register. Reads from those addresses return zero.
- R11: Writing zero to the control field with the one-shot bit set disables the path: `active_ctrl_o` becomes zero after the commit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Read data: working value low half, shadow value high half |
| frame_end_i | input | 1 | Single-cycle frame-end pulse, same clock domain |
| active_ctrl_o | output | CTRL_W | Shadow control field driven to the datapath |
| active_field_o | output | NUM_FIELDS*FIELD_W | Shadow fields driven to the datapath, field 0 in the low bits |

## Verification
The bound checker watches the commit rules on every cycle. The active outputs hold still on any edge without a commit. A one-shot control write lands on the active control field two edges later. A frame-end edge with auto-commit set copies the working set. The one-shot bit reads zero, and out-of-range reads return zero. Some behaviours need a sequence of operations, so only the bench scenarios show them: the auto-commit bit staying armed over several frames, a single copy when both commit sources coincide with a field write pending, writes to out-of-range addresses leaving every field untouched, and the disable sequence.

// File: rtl/cfg_shadow_pkg.sv
package cfg_shadow_pkg;
  localparam int unsigned CTRL_ADDR = 0;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_IMM   = 2'd1,
    SRC_FRAME = 2'd2,
    SRC_BOTH  = 2'd3
  } commit_src_e;
endpackage

// File: rtl/cfg_shadow_reg.sv
module cfg_shadow_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         commit_i,
  output logic [W-1:0] work_o,
  output logic [W-1:0] shad_o
);
  logic [W-1:0] work_q, shad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_q <= '0;
      shad_q <= '0;
    end else begin
      if (wr_i)     work_q <= wdata_i;
      // copy takes the pre-edge working value
      if (commit_i) shad_q <= work_q;
    end
  end

  assign work_o = work_q;
  assign shad_o = shad_q;
endmodule

// File: rtl/cfg_commit_ctl.sv
module cfg_commit_ctl
  import cfg_shadow_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic imm_req_i,
  input  logic auto_wr_i,
  input  logic auto_d_i,
  input  logic frame_end_i,
  output logic commit_o,
  output logic auto_o
);
  logic        imm_q, auto_q;
  commit_src_e src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imm_q  <= 1'b0;
      auto_q <= 1'b0;
    end else begin
      imm_q <= imm_req_i;
      if (auto_wr_i) auto_q <= auto_d_i;
    end
  end

  // both sources on one edge merge into a single copy
  assign src      = commit_src_e'({frame_end_i & auto_q, imm_q});
  assign commit_o = (src != SRC_NONE);
  assign auto_o   = auto_q;
endmodule

// File: rtl/cfg_bus_dec.sv
module cfg_bus_dec
  import cfg_shadow_pkg::*;
#(
  parameter int unsigned NUM_FIELDS = 8,
  parameter int unsigned FIELD_W    = 16,
  parameter int unsigned CTRL_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 4
) (
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic [ADDR_W-1:0]             rd_addr_i,
  input  logic [CTRL_W-1:0]             ctrl_work_i,
  input  logic [CTRL_W-1:0]             ctrl_shad_i,
  input  logic                          auto_i,
  input  logic [NUM_FIELDS*FIELD_W-1:0] field_work_i,
  input  logic [NUM_FIELDS*FIELD_W-1:0] field_shad_i,
  output logic                          ctrl_wr_o,
  output logic [CTRL_W-1:0]             ctrl_wdata_o,
  output logic                          imm_req_o,
  output logic                          auto_wr_o,
  output logic                          auto_d_o,
  output logic [NUM_FIELDS-1:0]         field_wr_o,
  output logic [FIELD_W-1:0]            field_wdata_o,
  output logic [DATA_W-1:0]             rd_data_o
);
  localparam int unsigned HALF     = DATA_W / 2;
  localparam int unsigned IMM_BIT  = CTRL_W;
  localparam int unsigned AUTO_BIT = CTRL_W + 1;
  localparam int unsigned USED_W   = (FIELD_W > AUTO_BIT + 1) ? FIELD_W : AUTO_BIT + 1;

  logic ctrl_hit;
  logic unused_wr_bits;

  assign ctrl_hit       = wr_en_i && (wr_addr_i == ADDR_W'(CTRL_ADDR));
  assign ctrl_wr_o      = ctrl_hit;
  assign ctrl_wdata_o   = wr_data_i[CTRL_W-1:0];
  assign imm_req_o      = ctrl_hit && wr_data_i[IMM_BIT];
  assign auto_wr_o      = ctrl_hit;
  assign auto_d_o       = wr_data_i[AUTO_BIT];
  assign field_wdata_o  = wr_data_i[FIELD_W-1:0];
  assign unused_wr_bits = ^wr_data_i[DATA_W-1:USED_W];

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_wdec
    assign field_wr_o[i] = wr_en_i && (wr_addr_i == ADDR_W'(i + 1));
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_W'(CTRL_ADDR)) begin
      rd_data_o[CTRL_W-1:0]   = ctrl_work_i;
      rd_data_o[AUTO_BIT]     = auto_i;
      rd_data_o[HALF+:CTRL_W] = ctrl_shad_i;
    end else begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (rd_addr_i == ADDR_W'(i + 1)) begin
          rd_data_o[0+:FIELD_W]    = field_work_i[i*FIELD_W+:FIELD_W];
          rd_data_o[HALF+:FIELD_W] = field_shad_i[i*FIELD_W+:FIELD_W];
        end
      end
    end
  end
endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank
  import cfg_shadow_pkg::*;
#(
  parameter int unsigned NUM_FIELDS = 8,
  parameter int unsigned FIELD_W    = 16,
  parameter int unsigned CTRL_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic [ADDR_W-1:0]             rd_addr_i,
  output logic [DATA_W-1:0]             rd_data_o,
  input  logic                          frame_end_i,
  output logic [CTRL_W-1:0]             active_ctrl_o,
  output logic [NUM_FIELDS*FIELD_W-1:0] active_field_o
);
  localparam int unsigned BANK_W = NUM_FIELDS * FIELD_W;

  logic                  ctrl_wr, imm_req, auto_wr, auto_d, auto_q, commit;
  logic [CTRL_W-1:0]     ctrl_wdata, ctrl_work, ctrl_shad;
  logic [NUM_FIELDS-1:0] field_wr;
  logic [FIELD_W-1:0]    field_wdata;
  logic [BANK_W-1:0]     field_work, field_shad;

  cfg_bus_dec #(
    .NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W), .CTRL_W(CTRL_W),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_dec (
    .wr_en_i       (wr_en_i),
    .wr_addr_i     (wr_addr_i),
    .wr_data_i     (wr_data_i),
    .rd_addr_i     (rd_addr_i),
    .ctrl_work_i   (ctrl_work),
    .ctrl_shad_i   (ctrl_shad),
    .auto_i        (auto_q),
    .field_work_i  (field_work),
    .field_shad_i  (field_shad),
    .ctrl_wr_o     (ctrl_wr),
    .ctrl_wdata_o  (ctrl_wdata),
    .imm_req_o     (imm_req),
    .auto_wr_o     (auto_wr),
    .auto_d_o      (auto_d),
    .field_wr_o    (field_wr),
    .field_wdata_o (field_wdata),
    .rd_data_o     (rd_data_o)
  );

  cfg_commit_ctl u_commit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .imm_req_i   (imm_req),
    .auto_wr_i   (auto_wr),
    .auto_d_i    (auto_d),
    .frame_end_i (frame_end_i),
    .commit_o    (commit),
    .auto_o      (auto_q)
  );

  cfg_shadow_reg #(.W(CTRL_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (ctrl_wr),
    .wdata_i  (ctrl_wdata),
    .commit_i (commit),
    .work_o   (ctrl_work),
    .shad_o   (ctrl_shad)
  );

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    cfg_shadow_reg #(.W(FIELD_W)) u_fld (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (field_wr[i]),
      .wdata_i  (field_wdata),
      .commit_i (commit),
      .work_o   (field_work[i*FIELD_W+:FIELD_W]),
      .shad_o   (field_shad[i*FIELD_W+:FIELD_W])
    );
  end

  assign active_ctrl_o  = ctrl_shad;
  assign active_field_o = field_shad;
endmodule

// File: rtl/cfg_shadow_bank_chk.sv
module cfg_shadow_bank_chk #(
  parameter int unsigned NUM_FIELDS = 8,
  parameter int unsigned FIELD_W    = 16,
  parameter int unsigned CTRL_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 4
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          wr_en_i,
  input logic [ADDR_W-1:0]             wr_addr_i,
  input logic [CTRL_W:0]               ctrl_wdata_i,
  input logic [ADDR_W-1:0]             rd_addr_i,
  input logic [DATA_W-1:0]             rd_data_o,
  input logic                          frame_end_i,
  input logic [CTRL_W-1:0]             active_ctrl_o,
  input logic [NUM_FIELDS*FIELD_W-1:0] active_field_o,
  input logic                          commit_i,
  input logic                          auto_i,
  input logic [CTRL_W-1:0]             ctrl_work_i,
  input logic [NUM_FIELDS*FIELD_W-1:0] field_work_i
);
  p_hold_without_commit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> ($stable(active_ctrl_o) && $stable(active_field_o)));

  p_imm_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == '0 && ctrl_wdata_i[CTRL_W])
      |-> ##2 (active_ctrl_o == $past(ctrl_wdata_i[CTRL_W-1:0], 2)));

  p_imm_bit_reads_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == '0) |-> !rd_data_o[CTRL_W]);

  p_frame_commit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && auto_i)
      |=> (active_field_o == $past(field_work_i) && active_ctrl_o == $past(ctrl_work_i)));

  p_auto_readback_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == '0) |-> (rd_data_o[CTRL_W+1] == auto_i));

  p_oob_read_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i > ADDR_W'(NUM_FIELDS)) |-> (rd_data_o == '0));
endmodule

bind cfg_shadow_bank cfg_shadow_bank_chk #(
  .NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W), .CTRL_W(CTRL_W),
  .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_en_i        (wr_en_i),
  .wr_addr_i      (wr_addr_i),
  .ctrl_wdata_i   (wr_data_i[CTRL_W:0]),
  .rd_addr_i      (rd_addr_i),
  .rd_data_o      (rd_data_o),
  .frame_end_i    (frame_end_i),
  .active_ctrl_o  (active_ctrl_o),
  .active_field_o (active_field_o),
  .commit_i       (commit),
  .auto_i         (auto_q),
  .ctrl_work_i    (ctrl_work),
  .field_work_i   (field_work)
);

// File: tb/cfg_shadow_bank_tb.sv
module cfg_shadow_bank_tb;
  localparam int unsigned NF = 8;
  localparam int unsigned FW = 16;
  localparam int unsigned CW = 8;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 4;
  localparam int unsigned HALF = DW / 2;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned N_RAND = 3000;
  localparam logic [DW-1:0] IMM  = DW'(1) << CW;
  localparam logic [DW-1:0] AUTO = DW'(1) << (CW + 1);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic frame_end_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic [CW-1:0] active_ctrl_o;
  logic [NF*FW-1:0] active_field_o;

  logic [FW-1:0] m_work [NF];
  logic [FW-1:0] m_shad [NF];
  logic [CW-1:0] m_ctrl_w, m_ctrl_s;
  bit m_auto, m_imm;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  cfg_shadow_bank #(.NUM_FIELDS(NF), .FIELD_W(FW), .CTRL_W(CW), .DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .frame_end_i(frame_end_i), .active_ctrl_o(active_ctrl_o), .active_field_o(active_field_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
    logic [DW-1:0] r;
    r = '0;
    if (a == '0) begin
      r[CW-1:0]   = m_ctrl_w;
      r[CW+1]     = m_auto;
      r[HALF+:CW] = m_ctrl_s;
    end else if (a <= AW'(NF)) begin
      r[0+:FW]    = m_work[a-1];
      r[HALF+:FW] = m_shad[a-1];
    end
    return r;
  endfunction

  function automatic logic [NF*FW-1:0] exp_fields();
    logic [NF*FW-1:0] r;
    for (int i = 0; i < NF; i++) r[i*FW+:FW] = m_shad[i];
    return r;
  endfunction

  task automatic check(input string tag, input logic [NF*FW-1:0] act, input logic [NF*FW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_edge(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit fe);
    bit commit;
    commit = m_imm || (fe && m_auto);
    if (commit) begin
      m_ctrl_s = m_ctrl_w;
      for (int i = 0; i < NF; i++) m_shad[i] = m_work[i];
    end
    m_imm = we && (a == '0) && d[CW];
    if (we) begin
      if (a == '0) begin
        m_ctrl_w = d[CW-1:0];
        m_auto   = d[CW+1];
      end else if (a <= AW'(NF)) begin
        m_work[a-1] = d[FW-1:0];
      end
    end
  endtask

  task automatic step(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit fe);
    wr_en_i = we; wr_addr_i = a; wr_data_i = d; frame_end_i = fe;
    @(posedge clk_i);
    model_edge(we, a, d, fe);
    @(negedge clk_i);
    wr_en_i = 1'b0; frame_end_i = 1'b0;
  endtask

  task automatic check_rd(input string tag, input logic [AW-1:0] a);
    rd_addr_i = a;
    #1;
    check(tag, rd_data_o, exp_rd(a));
  endtask

  task automatic check_active(input string tag);
    check(tag, active_ctrl_o, m_ctrl_s);
    check(tag, active_field_o, exp_fields());
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    m_ctrl_w = '0; m_ctrl_s = '0; m_auto = 1'b0; m_imm = 1'b0;
    for (int i = 0; i < NF; i++) begin m_work[i] = '0; m_shad[i] = '0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    for (int a = 0; a < NF + 3; a++) check_rd("R1", AW'(a));
    check("R1", active_ctrl_o, '0);
    check("R1", active_field_o, '0);

    // R2 write stays pending
    step(1, 4, 'h1234, 0);
    check_rd("R2", 4);
    check("R2", active_field_o[3*FW+:FW], '0);

    // R3 one-shot commit, R4 bit not stored
    step(1, 0, IMM | 'h5A, 0);
    check("R3", active_ctrl_o, '0);
    check_rd("R4", 0);
    check("R4", rd_data_o[CW], '0);
    step(0, 0, 0, 0);
    check("R3", active_ctrl_o, 'h5A);
    check("R3", active_field_o[3*FW+:FW], 'h1234);
    check_rd("R9", 4);
    check("R9", rd_data_o, 'h1234_1234);
    check_rd("R9", 0);
    check("R9", rd_data_o, 'h005A_005A);

    // R11 disable through zero write plus commit
    step(1, 0, IMM, 0);
    step(0, 0, 0, 0);
    check("R11", active_ctrl_o, '0);

    // R5 deferred commit at frame end
    step(1, 1, 'hBEEF, 0);
    step(1, 0, AUTO, 0);
    repeat (3) step(0, 0, 0, 0);
    check("R5", active_field_o[0+:FW], '0);
    step(0, 0, 0, 1);
    check("R5", active_field_o[0+:FW], 'hBEEF);

    // R7 auto bit is sticky
    step(1, 1, 'h0101, 0);
    step(0, 0, 0, 1);
    check("R7", active_field_o[0+:FW], 'h0101);
    check_rd("R7", 0);
    check("R7", rd_data_o[CW+1], 1'b1);

    // R6 frame end ignored with auto clear
    step(1, 0, 0, 0);
    step(1, 2, 'h0007, 0);
    step(0, 0, 0, 1);
    check("R6", active_field_o[1*FW+:FW], '0);
    check_active("R6");

    // R8 both commit sources on one edge
    step(1, 3, 'h2222, 0);
    step(1, 0, IMM | AUTO, 0);
    step(1, 3, 'h3333, 1);
    check("R8", active_field_o[2*FW+:FW], 'h2222);
    step(0, 0, 0, 0);
    check("R8", active_field_o[2*FW+:FW], 'h2222);
    check_rd("R8", 3);
    check("R8", rd_data_o, 'h2222_3333);

    // R10 out-of-range addresses
    step(1, AW'(NF + 1), 'hFFFF_FFFF, 0);
    step(1, AW'(15), 'hFFFF_FFFF, 0);
    for (int a = 0; a <= NF; a++) check_rd("R10", AW'(a));
    check_rd("R10", AW'(NF + 1));
    check("R10", rd_data_o, '0);
    check_active("R10");

    // random mix
    for (int k = 0; k < N_RAND; k++) begin
      step(1'($urandom_range(0, 1)), AW'($urandom_range(0, NF + 2)), DW'($urandom),
           ($urandom_range(0, 7) == 0));
      check_rd("R9", AW'($urandom_range(0, NF + 2)));
      check_active("R2");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule